// File: doc/BRIEF.md
# Integer ALU with Status-Flag Generation

This block performs the two-operand integer operations of a byte-addressed processor datapath: add, add-with-carry, subtract, subtract-with-borrow, compare, and the three bitwise logic operations. Each operand can be 1, 2 or 4 bytes wide. The second operand can be narrower than the first, and is then sign-extended to the first operand's width. The block returns the result masked to the first operand's width, a full flag word, and a write-enable that tells the register or memory stage whether to commit the result.

Requests enter through a valid/ready stream and results leave through a second valid/ready stream. A single output register sits between them. A request is taken on a cycle with `in_valid` and `in_ready` both high, and its result appears one cycle later. The result stays unchanged while `out_valid` is high and `out_ready` is low. During that time `in_ready` is low, so back-pressure from the consumer reaches the producer in the same cycle. When the output register is empty, or is being drained in the current cycle, `in_ready` is high.

Top module: `int_alu_flags`

## Requirements
- R1: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR. Size codes are 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. `out_result` holds the result masked to the width of `in_asz`, with all bits above that width zero.
- R2: The second operand is sign-extended from the width of `in_bsz` to the width of `in_asz` before it is used.
- R3: Add-with-carry adds flag bit 0 of `in_flags`. Subtract-with-borrow subtracts flag bit 0.
- R4: Carry (flag bit 0) is set when the exact, unmasked sum or difference has any bit set above the operand width. A negative difference counts as such a borrow.
- R5: Overflow (flag bit 11) is set in these cases. For additions, when both operands have the same sign and the result's sign differs from it. For subtractions, when the operands have different signs and the result's sign differs from the first operand's sign.
- R6: Auxiliary carry (flag bit 4) is set in these cases. For additions, when the low nibbles plus the carry-in reach 16. For subtractions, when the first operand's low nibble is below the second operand's low nibble.
- R7: Sign (flag bit 7) equals the top bit of the masked result. Zero (flag bit 6) is set when the masked result is all zeros.
- R8: Parity (flag bit 2) is set when bits 7..0 of the result hold an even number of ones.
- R9: The AND, OR and XOR operations clear the carry, overflow and auxiliary flags, and set sign, zero and parity from their result.
- R10: Every flag bit other than 0, 2, 4, 6, 7 and 11 is copied unchanged from `in_flags`.
- R11: Compare produces the same flags as subtract, with `out_wr_en` low. Every other operation drives `out_wr_en` high.
- R12: A request accepted on a clock edge is presented at the output after that edge. The output is held stable while `out_valid` is high and `out_ready` is low. Results leave in the order their requests were accepted.
- R13: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | 32 | First operand (destination) |
| in_asz | input | 2 | First operand size code |
| in_b | input | 32 | Second operand (source) |
| in_bsz | input | 2 | Second operand size code |
| in_flags | input | 32 | Incoming flag word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Masked result |
| out_flags | output | 32 | Updated flag word |
| out_wr_en | output | 1 | Commit the result (low for compare) |

## Verification
The assertions check the following on every cycle:
- the pass-through of non-status flag bits;
- the compare write-enable rule;
- clearing of carry, overflow and auxiliary carry by logic operations;
- the zero and parity flags against the presented result;
- zeroing of the high bits for byte results;
- the one-cycle latency and the hold under back-pressure.

The arithmetic values themselves can only be shown by the bench's scenarios. These values are the carry and borrow, the signed overflow, the nibble carry with and without carry-in, and the sign-extension of a narrower second operand. The bench scenarios compare every result against an independent reference model, using both hand-picked corner vectors and random traffic under random stalls.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_CMP = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } alu_op_e;

  // Status flag positions inside the flag word
  localparam int F_CF = 0;
  localparam int F_PF = 2;
  localparam int F_AF = 4;
  localparam int F_ZF = 6;
  localparam int F_SF = 7;
  localparam int F_OF = 11;

  // Size code to bit width, clipped to the datapath width
  function automatic int unsigned size_bits(input logic [1:0] code, input int unsigned max_w);
    int unsigned w;
    case (code)
      2'd0:    w = 8;
      2'd1:    w = 16;
      default: w = 32;
    endcase
    if (w > max_w) w = max_w;
    return w;
  endfunction

  function automatic logic is_logic_op(input alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic is_sub_op(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [1:0]        asz,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        bsz,
  output logic [DATA_W-1:0] a_m,
  output logic [DATA_W-1:0] b_x,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] topbit
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int W1    = IDX_W + 1;

  logic [W1-1:0]    aw;
  logic [W1-1:0]    bw;
  logic [IDX_W-1:0] b_top_idx;
  logic             b_sign;
  logic [DATA_W-1:0] b_ext;

  assign aw        = W1'(size_bits(asz, DATA_W));
  assign bw        = W1'(size_bits(bsz, DATA_W));
  assign b_top_idx = IDX_W'(bw - W1'(1));
  assign b_sign    = b[b_top_idx];

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign mask[i]   = (aw > W1'(i));
    assign topbit[i] = (aw == W1'(i + 1));
    assign b_ext[i]  = (bw > W1'(i)) ? b[i] : b_sign;
  end

  assign a_m = a & mask;
  assign b_x = b_ext & mask;

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a_m,
  input  logic [DATA_W-1:0] b_x,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] topbit,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags_out,
  output logic              wr_en
);
  localparam int EW = DATA_W + 1;
  localparam logic [FLAG_W-1:0] STATUS_MASK =
      (FLAG_W'(1) << F_CF) | (FLAG_W'(1) << F_PF) | (FLAG_W'(1) << F_AF) |
      (FLAG_W'(1) << F_ZF) | (FLAG_W'(1) << F_SF) | (FLAG_W'(1) << F_OF);

  logic          cin;
  logic [EW-1:0] ext_a, ext_b, ext_c, ext_res;
  logic [DATA_W-1:0] res;
  logic cf, of, af, sf, zf, pf;
  logic [FLAG_W-1:0] status;

  assign cin   = ((op == OP_ADC) || (op == OP_SBB)) ? flags_in[F_CF] : 1'b0;
  assign ext_a = {1'b0, a_m};
  assign ext_b = {1'b0, b_x};
  assign ext_c = EW'(cin);

  always_comb begin
    ext_res = '0;
    cf = 1'b0;
    of = 1'b0;
    af = 1'b0;
    if (is_logic_op(op)) begin
      unique case (op)
        OP_AND:  res = a_m & b_x;
        OP_OR:   res = a_m | b_x;
        default: res = a_m ^ b_x;
      endcase
    end else if (is_sub_op(op)) begin
      ext_res = ext_a - ext_b - ext_c;
      res     = ext_res[DATA_W-1:0] & mask;
      cf      = |(ext_res & ~{1'b0, mask});
      of      = |((a_m ^ b_x) & (a_m ^ res) & topbit);
      af      = a_m[3:0] < b_x[3:0];
    end else begin
      ext_res = ext_a + ext_b + ext_c;
      res     = ext_res[DATA_W-1:0] & mask;
      cf      = |(ext_res & ~{1'b0, mask});
      of      = |(~(a_m ^ b_x) & (a_m ^ res) & topbit);
      af      = ext_a[4] ^ ext_b[4] ^ ext_res[4];
    end
    sf = |(res & topbit);
    zf = (res == '0);
    pf = ~(^res[7:0]);
  end

  always_comb begin
    status         = '0;
    status[F_CF]   = cf;
    status[F_PF]   = pf;
    status[F_AF]   = af;
    status[F_ZF]   = zf;
    status[F_SF]   = sf;
    status[F_OF]   = of;
  end

  assign result    = res;
  assign flags_out = (flags_in & ~STATUS_MASK) | (status & STATUS_MASK);
  assign wr_en     = (op != OP_CMP);

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] d_result,
  input  logic [FLAG_W-1:0] d_flags,
  input  logic              d_wr_en,
  input  logic              out_ready,
  output logic              full,
  output logic [DATA_W-1:0] q_result,
  output logic [FLAG_W-1:0] q_flags,
  output logic              q_wr_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      q_result <= '0;
      q_flags  <= '0;
      q_wr_en  <= 1'b0;
    end else begin
      if (take) begin
        full     <= 1'b1;
        q_result <= d_result;
        q_flags  <= d_flags;
        q_wr_en  <= d_wr_en;
      end else if (out_ready) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [1:0]        in_asz,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_bsz,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [FLAG_W-1:0] out_flags,
  output logic              out_wr_en
);
  logic [DATA_W-1:0] a_m, b_x, mask, topbit;
  logic [DATA_W-1:0] c_result;
  logic [FLAG_W-1:0] c_flags;
  logic              c_wr_en;
  logic              full;
  logic              take;

  alu_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .a(in_a), .asz(in_asz), .b(in_b), .bsz(in_bsz),
    .a_m(a_m), .b_x(b_x), .mask(mask), .topbit(topbit)
  );

  alu_core #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_core (
    .op(alu_op_e'(in_op)), .a_m(a_m), .b_x(b_x), .mask(mask), .topbit(topbit),
    .flags_in(in_flags), .result(c_result), .flags_out(c_flags), .wr_en(c_wr_en)
  );

  assign in_ready = !full || out_ready;
  assign take     = in_valid && in_ready;

  alu_out_stage #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .take(take),
    .d_result(c_result), .d_flags(c_flags), .d_wr_en(c_wr_en),
    .out_ready(out_ready), .full(full),
    .q_result(out_result), .q_flags(out_flags), .q_wr_en(out_wr_en)
  );

  assign out_valid = full;

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [1:0]        in_asz,
  input logic [FLAG_W-1:0] in_flags,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [FLAG_W-1:0] out_flags,
  input logic              out_wr_en
);
  localparam logic [FLAG_W-1:0] SMASK =
      (FLAG_W'(1) << F_CF) | (FLAG_W'(1) << F_PF) | (FLAG_W'(1) << F_AF) |
      (FLAG_W'(1) << F_ZF) | (FLAG_W'(1) << F_SF) | (FLAG_W'(1) << F_OF);

  logic [2:0]        cap_op;
  logic [1:0]        cap_asz;
  logic [FLAG_W-1:0] cap_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op    <= '0;
      cap_asz   <= '0;
      cap_flags <= '0;
    end else if (in_valid && in_ready) begin
      cap_op    <= in_op;
      cap_asz   <= in_asz;
      cap_flags <= in_flags;
    end
  end

  p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
    $stable(out_flags) && $stable(out_wr_en));

  p_cmp_nowr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_wr_en == (cap_op != 3'd4)));

  p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_flags & ~SMASK) == (cap_flags & ~SMASK)));

  p_logic_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (cap_op >= 3'd5) |->
    !out_flags[F_CF] && !out_flags[F_OF] && !out_flags[F_AF]);

  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[F_ZF] == (out_result == '0)));

  p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[F_PF] == ($countones(out_result[7:0]) % 2 == 0)));

  p_byte_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (cap_asz == 2'd0) |-> (out_result[DATA_W-1:8] == '0));

endmodule

bind int_alu_flags alu_flags_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_flags_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_asz(in_asz), .in_flags(in_flags),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_flags(out_flags), .out_wr_en(out_wr_en)
);

// File: tb/test_int_alu_flags.sv
module test_int_alu_flags;
  typedef struct {
    logic [2:0]  op;
    logic [31:0] a;
    logic [1:0]  asz;
    logic [31:0] b;
    logic [1:0]  bsz;
    logic [31:0] fl;
  } stim_t;

  typedef struct {
    logic [31:0] res;
    logic [31:0] fl;
    logic        wr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [1:0]  in_asz = '0;
  logic [31:0] in_b = '0;
  logic [1:0]  in_bsz = '0;
  logic [31:0] in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic [31:0] out_flags;
  logic        out_wr_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  stim_t stimq[$];
  exp_t  expq[$];

  always #4 clk = ~clk;

  int_alu_flags i_int_alu_flags (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_asz(in_asz), .in_b(in_b), .in_bsz(in_bsz),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags), .out_wr_en(out_wr_en)
  );

  function automatic int width_of(input logic [1:0] code);
    if (code == 2'd0) return 8;
    if (code == 2'd1) return 16;
    return 32;
  endfunction

  // Behavioural reference written from the requirements
  function automatic exp_t model(input stim_t s);
    exp_t e;
    int aw = width_of(s.asz);
    int bw = width_of(s.bsz);
    longint unsigned amsk = (64'd1 << aw) - 64'd1;
    longint bsx = longint'({32'd0, s.b}) << (64 - bw);
    longint unsigned am, bm, c;
    longint unsigned cin;
    bit addk, subk;
    int ones;
    bsx = bsx >>> (64 - bw);                      // R2 sign extension
    am = longint'({32'd0, s.a}) & amsk;
    bm = bsx & amsk;
    cin = (s.op == 3'd1 || s.op == 3'd3) ? longint'(s.fl[0]) : 0;   // R3
    addk = (s.op <= 3'd1);
    subk = (s.op >= 3'd2 && s.op <= 3'd4);
    e.fl = s.fl;                                  // R10 untouched bits
    e.fl[0] = 0; e.fl[4] = 0; e.fl[11] = 0;
    if (addk) begin
      c = am + bm + cin;
      e.fl[11] = (am[aw-1] == bm[aw-1]) && (c[aw-1] != am[aw-1]);
      e.fl[4]  = ((am & 15) + (bm & 15) + cin) >= 16;
    end else if (subk) begin
      c = am - bm - cin;
      e.fl[11] = (am[aw-1] != bm[aw-1]) && (c[aw-1] != am[aw-1]);
      e.fl[4]  = (am & 15) < (bm & 15);
    end else begin
      if (s.op == 3'd5) c = am & bm;
      else if (s.op == 3'd6) c = am | bm;
      else c = am ^ bm;                           // R9: CF/OF/AF stay clear
    end
    if (addk || subk) e.fl[0] = (c & ~amsk) != 0; // R4
    c = c & amsk;
    e.fl[7] = c[aw-1];                            // R7
    e.fl[6] = (c == 0);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(c[i]);
    e.fl[2] = (ones % 2 == 0);                    // R8
    e.res = c[31:0];
    e.wr = (s.op != 3'd4);                        // R11
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input exp_t e);
    check(out_result == e.res, "R1", "result", out_result, e.res);
    check(out_flags[0] == e.fl[0], "R4", "carry", 32'(out_flags[0]), 32'(e.fl[0]));
    check(out_flags[11] == e.fl[11], "R5", "overflow", 32'(out_flags[11]), 32'(e.fl[11]));
    check(out_flags[4] == e.fl[4], "R6", "aux", 32'(out_flags[4]), 32'(e.fl[4]));
    check(out_flags[7:6] == e.fl[7:6], "R7", "sign/zero", 32'(out_flags[7:6]), 32'(e.fl[7:6]));
    check(out_flags[2] == e.fl[2], "R8", "parity", 32'(out_flags[2]), 32'(e.fl[2]));
    check((out_flags & ~32'h8D5) == (e.fl & ~32'h8D5), "R10", "other flags",
          out_flags, e.fl);
    check(out_wr_en == e.wr, "R11", "write enable", 32'(out_wr_en), 32'(e.wr));
  endtask

  function automatic stim_t mk(input logic [2:0] op, input logic [31:0] a, input logic [1:0] asz,
                               input logic [31:0] b, input logic [1:0] bsz, input logic [31:0] fl);
    stim_t s;
    s.op = op; s.a = a; s.asz = asz; s.b = b; s.bsz = bsz; s.fl = fl;
    return s;
  endfunction

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog: run did not finish actual=%0d expected<=150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : main
    bit hold_prev = 1'b0;
    logic [31:0] hres, hfl;
    logic hwr;
    int idle;

    // Directed corner vectors
    stimq.push_back(mk(3'd0, 32'hFF, 2'd0, 32'h01, 2'd0, 32'h0));          // R4 carry, R7 zero, R6 aux
    stimq.push_back(mk(3'd0, 32'h7F, 2'd0, 32'h01, 2'd0, 32'hFFFF_FFFF));  // R5 overflow, R10
    stimq.push_back(mk(3'd2, 32'h0000, 2'd1, 32'h0001, 2'd1, 32'h0));      // R4 borrow
    stimq.push_back(mk(3'd2, 32'h8000_0000, 2'd2, 32'h1, 2'd2, 32'h0));    // R5 sub overflow
    stimq.push_back(mk(3'd1, 32'hFFFF_FFFF, 2'd2, 32'h0, 2'd2, 32'h1));    // R3 carry-in
    stimq.push_back(mk(3'd1, 32'h0F, 2'd0, 32'h00, 2'd0, 32'h1));          // R3, R6 aux via carry-in
    stimq.push_back(mk(3'd3, 32'h10, 2'd0, 32'h0F, 2'd0, 32'h1));          // R3 borrow-in
    stimq.push_back(mk(3'd0, 32'h1000, 2'd2, 32'h80, 2'd0, 32'h0));        // R2 sign extension
    stimq.push_back(mk(3'd0, 32'h1000, 2'd1, 32'h7F, 2'd0, 32'h0));        // R2 positive
    stimq.push_back(mk(3'd5, 32'hF0F0, 2'd1, 32'hFF00, 2'd1, 32'hFFFF_FFFF)); // R9
    stimq.push_back(mk(3'd6, 32'h0, 2'd0, 32'h0, 2'd0, 32'hFFFF_FFFF));    // R9 zero result
    stimq.push_back(mk(3'd7, 32'h5A, 2'd0, 32'hA5, 2'd0, 32'h0000_0801));  // R9, R8 parity
    stimq.push_back(mk(3'd4, 32'h5, 2'd2, 32'h7, 2'd2, 32'h0));            // R11 compare
    stimq.push_back(mk(3'd2, 32'h10, 2'd0, 32'h01, 2'd0, 32'h0));          // R6 nibble borrow
    stimq.push_back(mk(3'd0, 32'h1234_5678, 2'd3, 32'h1111_1111, 2'd3, 32'h0)); // R1 size code 3
    stimq.push_back(mk(3'd0, 32'hABCD_12F0, 2'd0, 32'h0, 2'd0, 32'h0));    // R1 byte mask, R8
    for (int k = 0; k < 3000; k++)
      stimq.push_back(mk(3'($urandom_range(0, 7)), $urandom, 2'($urandom_range(0, 3)),
                         $urandom, 2'($urandom_range(0, 3)), $urandom));

    // Reset state, R13
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R13", "out_valid in reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R13", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R13", "out_valid after reset", 32'(out_valid), 32'd0);

    idle = 0;
    while ((stimq.size() != 0 || expq.size() != 0 || out_valid) && idle < 50) begin
      @(negedge clk);
      // R12: output held since last cycle under back-pressure
      if (hold_prev) begin
        check(out_valid && out_result == hres && out_flags == hfl && out_wr_en == hwr,
              "R12", "hold under stall", out_result, hres);
      end
      if (stimq.size() != 0) begin
        in_valid = ($urandom_range(0, 3) != 0);
        in_op = stimq[0].op; in_a = stimq[0].a; in_asz = stimq[0].asz;
        in_b = stimq[0].b; in_bsz = stimq[0].bsz; in_flags = stimq[0].fl;
      end else begin
        in_valid = 1'b0;
      end
      out_ready = ($urandom_range(0, 3) != 0);
      #1;
      hold_prev = out_valid && !out_ready;
      hres = out_result; hfl = out_flags; hwr = out_wr_en;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R12", "unexpected output", out_result, 32'd0);
        end else begin
          compare(expq.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        expq.push_back(model(stimq.pop_front()));
      end
      if (stimq.size() == 0 && expq.size() == 0) idle++;
    end
    check(expq.size() == 0, "R12", "results outstanding", 32'(expq.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule